// File: doc/BRIEF.md
# Serial Controller Register Block with Prioritised Interrupt

This block is the processor-side register set of a byte-oriented serial controller. The host sees eight byte-wide locations selected by a 3-bit offset. Reads and writes are single-cycle strobes. Read data is combinational from the current state, and every side effect of an access lands on the following clock edge.

Behind the window sit a 16-bit baud divisor, an interrupt enable register, an interrupt identification value, line control, modem control, line status, modem status and a scratch byte. Bytes written for transmission leave on a valid/ready output stream. Bytes and break events arrive on a receive port. A single level interrupt reports the highest-priority pending cause.

The transmit stream follows valid/ready rules. Once `tx_valid` rises, the byte and the valid stay put until `tx_ready` is seen high at a clock edge. The one exception is a new host write while the byte is still held, which replaces the held byte. The receive side has no back-pressure of its own. `rx_ready` is a hint that drops while an unread byte is held. A source that ignores the hint still has its byte accepted, and that byte overwrites the held one.

Top module: `sercom_regs`

## Requirements
- R1: After reset, offset 5 (line status) reads 0x60, offset 2 (identification) reads 0x01, `irq` and `tx_valid` are low, `rx_ready` is high and `baud_div` is 0.
- R2: While line-control bit 7 is set, offsets 0 and 1 read and write the low and high divisor bytes shown on `baud_div`. While that bit is clear, offset 1 is the interrupt enable register.
- R3: Offsets 3, 4, 6 and 7 read back the last value written. Writes to offsets 2 and 5 change nothing that is visible.
- R4: A write to offset 0 with line-control bit 7 clear raises `tx_valid` with that byte on the next cycle and clears line-status bit 5. At the edge where the byte is taken, line-status bits 5 and 6 become set and the transmit-pending flag is set.
- R5: While `tx_ready` is low, `tx_valid` and `tx_data` hold. A further data write during the hold replaces `tx_data`.
- R6: A received byte (`rx_valid` high, `rx_break` low) is stored in the receive buffer and sets line-status bit 0, which drops `rx_ready`. A byte that arrives while bit 0 is already set overwrites the buffer.
- R7: A break (`rx_valid` and `rx_break` high) stores 0 in the buffer and sets line-status bits 4 and 0.
- R8: Reading offset 0 with line-control bit 7 clear returns the buffer. It clears line-status bits 0 and 4 from the next cycle, which raises `rx_ready` again.
- R9: The identification value is 0x04 when line-status bit 0 and enable bit 0 are both set. Failing that, it is 0x02 when the transmit-pending flag and enable bit 1 are both set. Otherwise it is 0x01. `irq` is high exactly when the value is not 0x01, and an enable write takes effect on the next cycle.
- R10: A read of offset 2 that returns 0x02 clears the transmit-pending flag, so the next read of offset 2 returns 0x01 unless another cause is active.
- R11: With modem-control bit 4 set, offset 6 reads modem-control bits 3:2 in bits 7:6, bit 1 in bit 4 and bit 0 in bit 5, with all other bits zero. With bit 4 clear, offset 6 reads the stored modem-status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| baud_div | output | 16 | Divisor latch contents |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit sink accepts the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive event strobe |
| rx_break | input | 1 | Qualifies `rx_valid` as a break event |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | High while no unread byte is held |
| irq | output | 1 | Level interrupt request |

## Verification
Read data belongs to the cycle of the read strobe. It is sampled mid-cycle, before the edge that applies the read's side effects. A write, receive event or transmit handoff is visible in status, `irq`, `rx_ready` and `tx_valid` one cycle after its strobe, because the identification value is combinational on registered state.

The bench therefore gives each access exactly one cycle and checks results on the access that follows. For the transmit path, line status read in the cycle right after a data write still shows bit 5 clear. Bit 5 is seen set, and the pending interrupt is seen, only one cycle after that.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  typedef enum logic [2:0] {
    OFS_DATA    = 3'd0,
    OFS_IEN     = 3'd1,
    OFS_IID     = 3'd2,
    OFS_LCTL    = 3'd3,
    OFS_MCTL    = 3'd4,
    OFS_LSTAT   = 3'd5,
    OFS_MSTAT   = 3'd6,
    OFS_SCRATCH = 3'd7
  } ofs_e;

  localparam logic [7:0] IID_NONE = 8'h01;
  localparam logic [7:0] IID_TXE  = 8'h02;
  localparam logic [7:0] IID_RXD  = 8'h04;

  localparam int LC_DIVSEL = 7;
  localparam int MC_LOOP   = 4;
  localparam int IE_RXD    = 0;
  localparam int IE_TXE    = 1;

endpackage

// File: rtl/sercom_rx_hold.sv
module sercom_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_break,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rd_buf,
  output logic [DATA_W-1:0] buf_q,
  output logic              dr_q,
  output logic              bi_q
);

  // arrival beats a same-cycle buffer read; break only sets, read only clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      dr_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      if (rx_valid) begin
        buf_q <= rx_break ? '0 : rx_data;
        dr_q  <= 1'b1;
      end else if (rd_buf) begin
        dr_q  <= 1'b0;
      end
      if (rx_valid && rx_break) bi_q <= 1'b1;
      else if (rd_buf)          bi_q <= 1'b0;
    end
  end

  p_rx_sets_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_break |=> dr_q && buf_q == $past(rx_data));

  p_break_loads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_break |=> dr_q && bi_q && buf_q == '0);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_buf && !rx_valid |=> !dr_q && !bi_q);

endmodule

// File: rtl/sercom_tx_hold.sv
module sercom_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_thr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              iid_ack,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              thre_q,
  output logic              pend_q
);

  logic handoff;
  assign handoff = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      thre_q   <= 1'b1;
      pend_q   <= 1'b0;
    end else if (wr_thr) begin
      tx_valid <= 1'b1;
      tx_data  <= wdata;
      thre_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else if (handoff) begin
      tx_valid <= 1'b0;
      thre_q   <= 1'b1;
      pend_q   <= 1'b1;
    end else if (iid_ack) begin
      pend_q   <= 1'b0;
    end
  end

  p_write_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> tx_valid && !thre_q && tx_data == $past(wdata));

  p_handoff_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    handoff && !wr_thr |=> !tx_valid && thre_q && pend_q);

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !wr_thr |=> tx_valid && $stable(tx_data));

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    iid_ack && !handoff && !wr_thr |=> !pend_q);

endmodule

// File: rtl/sercom_int_eval.sv
module sercom_int_eval
  import sercom_pkg::*;
(
  input  logic       dr,
  input  logic       pend,
  input  logic       en_rxd,
  input  logic       en_txe,
  output logic [7:0] iid,
  output logic       irq
);

  // receive data outranks transmit empty
  always_comb begin
    if (dr && en_rxd)        iid = IID_RXD;
    else if (pend && en_txe) iid = IID_TXE;
    else                     iid = IID_NONE;
  end

  assign irq = (iid != IID_NONE);

endmodule

// File: rtl/sercom_regs.sv
module sercom_regs
  import sercom_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_BYTES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [DIV_BYTES*DATA_W-1:0] baud_div,
  output logic                       tx_valid,
  input  logic                       tx_ready,
  output logic [DATA_W-1:0]          tx_data,
  input  logic                       rx_valid,
  input  logic                       rx_break,
  input  logic [DATA_W-1:0]          rx_data,
  output logic                       rx_ready,
  output logic                       irq
);

  localparam int DIV_W = DIV_BYTES * DATA_W;

  ofs_e ofs;
  assign ofs = ofs_e'(bus_addr);

  logic [DATA_W-1:0] ien_q, lctl_q, mctl_q, mstat_q, scr_q;
  logic [DIV_W-1:0]  div_q;
  logic              divsel;
  logic              wr_thr, rd_buf, iid_ack;
  logic [DATA_W-1:0] rbuf;
  logic              dr, bi, thre, pend;
  logic [7:0]        iid;
  logic [DATA_W-1:0] lstat, mview;

  assign divsel  = lctl_q[LC_DIVSEL];
  assign wr_thr  = bus_wr && ofs == OFS_DATA && !divsel;
  assign rd_buf  = bus_rd && ofs == OFS_DATA && !divsel;
  assign iid_ack = bus_rd && ofs == OFS_IID && iid[2:0] == IID_TXE[2:0];

  // divisor bytes share offsets 0.. with data and enable registers
  for (genvar g = 0; g < DIV_BYTES; g++) begin : g_div
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        div_q[g*DATA_W +: DATA_W] <= '0;
      else if (bus_wr && divsel && bus_addr == 3'(g))
        div_q[g*DATA_W +: DATA_W] <= bus_wdata;
    end
  end
  assign baud_div = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= '0;
      lctl_q  <= '0;
      mctl_q  <= '0;
      mstat_q <= '0;
      scr_q   <= '0;
    end else if (bus_wr) begin
      case (ofs)
        OFS_IEN:     if (!divsel) ien_q <= bus_wdata;
        OFS_LCTL:    lctl_q  <= bus_wdata;
        OFS_MCTL:    mctl_q  <= bus_wdata;
        OFS_MSTAT:   mstat_q <= bus_wdata;
        OFS_SCRATCH: scr_q   <= bus_wdata;
        default:     ;
      endcase
    end
  end

  sercom_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_break(rx_break), .rx_data(rx_data),
    .rd_buf(rd_buf), .buf_q(rbuf), .dr_q(dr), .bi_q(bi)
  );

  sercom_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_thr(wr_thr), .wdata(bus_wdata), .iid_ack(iid_ack),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .thre_q(thre), .pend_q(pend)
  );

  sercom_int_eval u_int (
    .dr(dr), .pend(pend), .en_rxd(ien_q[IE_RXD]), .en_txe(ien_q[IE_TXE]),
    .iid(iid), .irq(irq)
  );

  assign rx_ready = !dr;

  // transmitter-empty (bit 6) is never cleared in this model
  always_comb begin
    lstat    = '0;
    lstat[0] = dr;
    lstat[4] = bi;
    lstat[5] = thre;
    lstat[6] = 1'b1;
  end

  always_comb begin
    if (mctl_q[MC_LOOP]) begin
      mview      = '0;
      mview[7:6] = mctl_q[3:2];
      mview[4]   = mctl_q[1];
      mview[5]   = mctl_q[0];
    end else begin
      mview = mstat_q;
    end
  end

  always_comb begin
    case (ofs)
      OFS_DATA:    bus_rdata = divsel ? div_q[0 +: DATA_W] : rbuf;
      OFS_IEN:     bus_rdata = divsel ? div_q[DATA_W +: DATA_W] : ien_q;
      OFS_IID:     bus_rdata = iid;
      OFS_LCTL:    bus_rdata = lctl_q;
      OFS_MCTL:    bus_rdata = mctl_q;
      OFS_LSTAT:   bus_rdata = lstat;
      OFS_MSTAT:   bus_rdata = mview;
      default:     bus_rdata = scr_q;
    endcase
  end

  p_enable_takes_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && ofs == OFS_IEN && !divsel && bus_wdata[IE_RXD] && (dr || rx_valid)
    |=> irq);

  p_ignored_writes_keep_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (ofs == OFS_IID || ofs == OFS_LSTAT)
    |=> $stable(ien_q) && $stable(lctl_q) && $stable(mctl_q) && $stable(scr_q));

endmodule

// File: tb/test_sercom_regs.sv
module test_sercom_regs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [15:0] baud_div;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_break;
  logic [7:0]  rx_data;
  logic        rx_ready, irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  sercom_regs i_sercom_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_div(baud_div), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_break(rx_break),
    .rx_data(rx_data), .rx_ready(rx_ready), .irq(irq)
  );

  // vector: {op[1:0], addr[2:0], data[7:0], expect[7:0], irq, req[3:0]}
  // op 0 write, 1 read and check, 2 receive byte, 3 receive break
  localparam int NV = 48;
  localparam logic [25:0] VECS [0:NV-1] = '{
    {2'd1,3'd5,8'h00,8'h60,1'b0,4'd1},  // R1 line status
    {2'd1,3'd2,8'h00,8'h01,1'b0,4'd1},  // R1 identification
    {2'd0,3'd3,8'h80,8'h00,1'b0,4'd2},  // R2 select divisor
    {2'd0,3'd0,8'h34,8'h00,1'b0,4'd2},
    {2'd0,3'd1,8'h12,8'h00,1'b0,4'd2},
    {2'd1,3'd0,8'h00,8'h34,1'b0,4'd2},
    {2'd1,3'd1,8'h00,8'h12,1'b0,4'd2},
    {2'd0,3'd3,8'h03,8'h00,1'b0,4'd3},  // R3 line control
    {2'd1,3'd3,8'h00,8'h03,1'b0,4'd3},
    {2'd1,3'd1,8'h00,8'h00,1'b0,4'd2},  // R2 enable reg untouched
    {2'd0,3'd4,8'h0B,8'h00,1'b0,4'd3},
    {2'd1,3'd4,8'h00,8'h0B,1'b0,4'd3},
    {2'd0,3'd6,8'hC3,8'h00,1'b0,4'd3},
    {2'd1,3'd6,8'h00,8'hC3,1'b0,4'd3},
    {2'd0,3'd7,8'h5A,8'h00,1'b0,4'd3},
    {2'd1,3'd7,8'h00,8'h5A,1'b0,4'd3},
    {2'd0,3'd2,8'hFF,8'h00,1'b0,4'd3},  // R3 ignored
    {2'd1,3'd2,8'h00,8'h01,1'b0,4'd3},
    {2'd0,3'd5,8'h00,8'h00,1'b0,4'd3},  // R3 ignored
    {2'd1,3'd5,8'h00,8'h60,1'b0,4'd3},
    {2'd0,3'd1,8'h02,8'h00,1'b0,4'd9},  // R9 enable tx cause
    {2'd1,3'd2,8'h00,8'h01,1'b0,4'd9},
    {2'd0,3'd0,8'h41,8'h00,1'b0,4'd4},  // R4 send
    {2'd1,3'd5,8'h00,8'h40,1'b0,4'd4},
    {2'd1,3'd2,8'h00,8'h02,1'b1,4'd9},
    {2'd1,3'd2,8'h00,8'h01,1'b0,4'd10}, // R10
    {2'd1,3'd5,8'h00,8'h60,1'b0,4'd4},
    {2'd2,3'd0,8'h77,8'h00,1'b0,4'd6},  // R6 receive
    {2'd1,3'd5,8'h00,8'h61,1'b0,4'd6},
    {2'd0,3'd1,8'h03,8'h00,1'b0,4'd9},
    {2'd0,3'd0,8'h42,8'h00,1'b0,4'd4},
    {2'd1,3'd2,8'h00,8'h04,1'b1,4'd9},  // R9 priority
    {2'd1,3'd0,8'h00,8'h77,1'b1,4'd8},  // R8
    {2'd1,3'd2,8'h00,8'h02,1'b1,4'd9},
    {2'd1,3'd2,8'h00,8'h01,1'b0,4'd10},
    {2'd3,3'd0,8'hEE,8'h00,1'b0,4'd7},  // R7 break
    {2'd1,3'd5,8'h00,8'h71,1'b1,4'd7},
    {2'd1,3'd0,8'h00,8'h00,1'b1,4'd7},
    {2'd1,3'd5,8'h00,8'h60,1'b0,4'd8},
    {2'd2,3'd0,8'h11,8'h00,1'b0,4'd6},
    {2'd2,3'd0,8'h22,8'h00,1'b0,4'd6},  // R6 overwrite
    {2'd1,3'd0,8'h00,8'h22,1'b1,4'd6},
    {2'd0,3'd4,8'h1F,8'h00,1'b0,4'd11}, // R11 loopback
    {2'd1,3'd6,8'h00,8'hF0,1'b0,4'd11},
    {2'd0,3'd4,8'h15,8'h00,1'b0,4'd11},
    {2'd1,3'd6,8'h00,8'h60,1'b0,4'd11},
    {2'd0,3'd4,8'h00,8'h00,1'b0,4'd11},
    {2'd1,3'd6,8'h00,8'hC3,1'b0,4'd11}
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_strobes();
    bus_wr = 1'b0; bus_rd = 1'b0; rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  // one-cycle access; read data sampled mid-cycle before the edge
  task automatic access(input logic [1:0] op, input logic [2:0] a,
                        input logic [7:0] d, input logic [7:0] exp,
                        input logic exp_irq, input int req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; rx_data = d;
    case (op)
      2'd0: bus_wr = 1'b1;
      2'd1: bus_rd = 1'b1;
      2'd2: rx_valid = 1'b1;
      default: begin rx_valid = 1'b1; rx_break = 1'b1; end
    endcase
    #5;
    if (op == 2'd1) begin
      check(bus_rdata == exp, req, $sformatf("read offset %0d", a), 16'(bus_rdata), 16'(exp));
      check(irq == exp_irq, req, "irq", 16'(irq), 16'(exp_irq));
    end
    @(posedge clk); #1;
    clear_strobes();
  endtask

  task automatic idle();
    @(negedge clk); #5;
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_ready = 1'b1; bus_addr = '0; bus_wdata = '0; rx_data = '0;
    clear_strobes();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle();
    // R1 reset outputs
    check(!tx_valid, 1, "tx_valid", 16'(tx_valid), 16'd0);
    check(rx_ready, 1, "rx_ready", 16'(rx_ready), 16'd1);
    check(!irq, 1, "irq", 16'(irq), 16'd0);
    check(baud_div == 16'd0, 1, "baud_div", baud_div, 16'd0);

    for (int i = 0; i < NV; i++)
      access(VECS[i][25:24], VECS[i][23:21], VECS[i][20:13], VECS[i][12:5],
             VECS[i][4], int'(VECS[i][3:0]));

    // R2 divisor on its port
    check(baud_div == 16'h1234, 2, "baud_div", baud_div, 16'h1234);
    // R8 buffer read re-opened the receive side
    check(rx_ready, 8, "rx_ready", 16'(rx_ready), 16'd1);

    // R5 back-pressure: byte held, then replaced, then taken
    tx_ready = 1'b0;
    access(2'd0, 3'd0, 8'h55, 8'h00, 1'b0, 5);
    idle(); idle(); idle();
    check(tx_valid, 5, "tx_valid held", 16'(tx_valid), 16'd1);
    check(tx_data == 8'h55, 5, "tx_data held", 16'(tx_data), 16'h55);
    access(2'd1, 3'd5, 8'h00, 8'h40, 1'b0, 4);
    access(2'd0, 3'd0, 8'h66, 8'h00, 1'b0, 5);
    idle();
    check(tx_data == 8'h66, 5, "tx_data replaced", 16'(tx_data), 16'h66);
    @(negedge clk); tx_ready = 1'b1; #5;
    check(tx_valid, 5, "tx_valid at handoff", 16'(tx_valid), 16'd1);
    idle();
    check(!tx_valid, 4, "tx_valid after handoff", 16'(tx_valid), 16'd0);
    check(irq, 9, "irq tx pending", 16'(irq), 16'd1);
    access(2'd1, 3'd5, 8'h00, 8'h60, 1'b1, 4);

    // R6 receive drops rx_ready
    access(2'd2, 3'd0, 8'h9A, 8'h00, 1'b0, 6);
    idle();
    check(!rx_ready, 6, "rx_ready after byte", 16'(rx_ready), 16'd0);

    // R1 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle();
    check(!tx_valid, 1, "tx_valid after reset", 16'(tx_valid), 16'd0);
    check(rx_ready, 1, "rx_ready after reset", 16'(rx_ready), 16'd1);
    check(baud_div == 16'd0, 1, "baud_div after reset", baud_div, 16'd0);
    access(2'd1, 3'd5, 8'h00, 8'h60, 1'b0, 1);
    access(2'd1, 3'd2, 8'h00, 8'h01, 1'b0, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule